// File: doc/BRIEF.md
# Board I/O Configuration Register Bank

This block is the byte-wide register bank that a legacy PC system board exposes in its I/O space. The host presents a 16-bit port address with a read strobe or a write strobe, synchronous to the block clock. The bank holds a status byte, a setup byte, an option byte and four general-purpose bytes. It also answers with a fixed 16-bit board identifier that is chosen by a parameter.

The option byte configures the on-board serial and parallel ports. The bank decodes it into enable and select outputs that steer those two controllers. A lock bit in the setup byte can freeze the option byte against writes. The status byte collects event bits that other on-board logic raises through a set input. A read of the status byte clears it, so software observes each event once.

Top module: `board_cfg_regs`

## Requirements
- R1: After synchronous active-high reset, every stored byte is 0x00 except the option byte, which is 0x10. The outputs then show the parallel port enabled with select 0, and the serial port disabled with com_sel low.
- R2: rd_data is loaded on the clock edge that samples rd_stb high, so it is valid one cycle after the strobe. It holds its value while rd_stb is low.
- R3: Reading port 0x0091 returns the status byte, and the same edge clears the byte to 0x00. The clear happens only on the first cycle of a strobe. A strobe held over several cycles therefore clears the byte once, and later cycles return what has been set since.
- R4: Each 1 bit on stat_set sets the matching status bit on that clock edge. A set in the same cycle as a clearing read wins, so the bit stays 1 for the next read. The current read still returns the value from before the clear.
- R5: Port 0x0094 is the setup byte and can be written and read back.
- R6: A write to port 0x0102 is accepted only while bit 7 of the setup byte is 0. When that bit is 1, the option byte and all derived outputs keep their old values.
- R7: A read of port 0x0102 returns the option byte with bit 3 forced to 1.
- R8: serial_en equals option bit 2. com_sel equals option bit 3 while serial_en is 1, where 1 selects the first serial address and IRQ pair and 0 selects the second. com_sel is 0 while serial_en is 0.
- R9: lpt_en is 1 when option bit 4 is 1 and option bits 6:5 are not 3. lpt_base_sel then equals bits 6:5, where 0 is the monochrome-adapter base, 1 is LPT1 and 2 is LPT2. Otherwise lpt_en is 0 and lpt_base_sel is 0. The outputs change on the edge that accepts the option write.
- R10: Ports 0x0103, 0x0104, 0x0105 and 0x0190 are plain byte registers that can be written and read back, each independent of the others.
- R11: Ports 0x0100 and 0x0101 return the low byte and the high byte of the BOARD_ID parameter.
- R12: A read of any other port returns 0xFF. Writes to 0x0091, 0x0100, 0x0101 and to undecoded ports change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | I/O port address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| stat_set | input | 8 | Per-bit set requests for the status byte |
| rd_data | output | 8 | Registered read data |
| serial_en | output | 1 | On-board serial port enable |
| com_sel | output | 1 | Serial address/IRQ pair select (1 = first) |
| lpt_en | output | 1 | On-board parallel port enable |
| lpt_base_sel | output | 2 | Parallel base select (0 mono, 1 LPT1, 2 LPT2) |

## Verification
Two functions can meet on the status byte in the same cycle: a hardware set request and the clear caused by a read. The bench provokes this by driving stat_set during the first cycle of a read of 0x0091. It expects that read to return the bits from before the clear, and a second read to return exactly the bits set in that shared cycle. It also holds a read strobe on 0x0091 for several cycles and expects only the first cycle to clear. A third case writes the option byte while the lock bit is set, and the outputs must keep their old values.

// File: rtl/board_cfg_pkg.sv
package board_cfg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [15:0] PORT_STAT  = 16'h0091;
  localparam logic [15:0] PORT_SETUP = 16'h0094;
  localparam logic [15:0] PORT_ID_LO = 16'h0100;
  localparam logic [15:0] PORT_ID_HI = 16'h0101;
  localparam logic [15:0] PORT_OPT   = 16'h0102;
  localparam logic [15:0] PORT_GP0   = 16'h0103;
  localparam logic [15:0] PORT_GP1   = 16'h0104;
  localparam logic [15:0] PORT_GP2   = 16'h0105;
  localparam logic [15:0] PORT_GP3   = 16'h0190;

  localparam int NUM_GP = 4;

  // option byte field positions (decoded by the port steering logic)
  localparam int SETUP_LOCK_BIT = 7;
  localparam int OPT_SER_EN_BIT = 2;
  localparam int OPT_COM_BIT    = 3;
  localparam int OPT_LPT_EN_BIT = 4;
  localparam int OPT_LPT_LSB    = 5;

  localparam logic [BYTE_W-1:0] OPT_RESET = 8'h10;
  localparam logic [BYTE_W-1:0] OPEN_BUS  = 8'hFF;

  typedef enum logic [3:0] {
    SEL_STAT, SEL_SETUP, SEL_ID_LO, SEL_ID_HI, SEL_OPT,
    SEL_GP0, SEL_GP1, SEL_GP2, SEL_GP3, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e gp_sel(input int idx);
    case (idx)
      0:       return SEL_GP0;
      1:       return SEL_GP1;
      2:       return SEL_GP2;
      default: return SEL_GP3;
    endcase
  endfunction

  function automatic logic [1:0] lpt_field(input logic [BYTE_W-1:0] opt);
    return opt[OPT_LPT_LSB +: 2];
  endfunction

  function automatic logic lpt_enabled(input logic [BYTE_W-1:0] opt);
    return opt[OPT_LPT_EN_BIT] && (lpt_field(opt) != 2'b11);
  endfunction

  function automatic logic com_first(input logic [BYTE_W-1:0] opt);
    return opt[OPT_SER_EN_BIT] & opt[OPT_COM_BIT];
  endfunction

  function automatic logic [BYTE_W-1:0] opt_readback(input logic [BYTE_W-1:0] opt);
    logic [BYTE_W-1:0] v;
    v = opt;
    v[OPT_COM_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/board_cfg_decode.sv
module board_cfg_decode
  import board_cfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (addr == ADDR_W'(PORT_STAT))  sel = SEL_STAT;
    else if (addr == ADDR_W'(PORT_SETUP)) sel = SEL_SETUP;
    else if (addr == ADDR_W'(PORT_ID_LO)) sel = SEL_ID_LO;
    else if (addr == ADDR_W'(PORT_ID_HI)) sel = SEL_ID_HI;
    else if (addr == ADDR_W'(PORT_OPT))   sel = SEL_OPT;
    else if (addr == ADDR_W'(PORT_GP0))   sel = SEL_GP0;
    else if (addr == ADDR_W'(PORT_GP1))   sel = SEL_GP1;
    else if (addr == ADDR_W'(PORT_GP2))   sel = SEL_GP2;
    else if (addr == ADDR_W'(PORT_GP3))   sel = SEL_GP3;
    else                                  sel = SEL_NONE;
  end
endmodule

// File: rtl/board_cfg_store.sv
module board_cfg_store
  import board_cfg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  reg_sel_e                      sel,
  input  logic                          rd_stb,
  input  logic                          wr_stb,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [BYTE_W-1:0]             stat_set,
  output logic [BYTE_W-1:0]             stat_q,
  output logic [BYTE_W-1:0]             setup_q,
  output logic [BYTE_W-1:0]             opt_q,
  output logic [NUM_GP-1:0][BYTE_W-1:0] gp_q,
  output logic                          opt_wr_ok,
  output logic                          stat_clr
);
  logic rd_stb_q;

  // clear only on the first cycle of a read strobe
  assign stat_clr  = rd_stb && !rd_stb_q && (sel == SEL_STAT);
  assign opt_wr_ok = wr_stb && (sel == SEL_OPT) && !setup_q[SETUP_LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) rd_stb_q <= 1'b0;
    else     rd_stb_q <= rd_stb;
  end

  // set requests win over the read clear
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_clr ? '0 : stat_q) | stat_set;
  end

  always_ff @(posedge clk) begin
    if (rst)                               setup_q <= '0;
    else if (wr_stb && sel == SEL_SETUP)   setup_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)            opt_q <= OPT_RESET;
    else if (opt_wr_ok) opt_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic gp_we;
    assign gp_we = wr_stb && (sel == gp_sel(g));
    always_ff @(posedge clk) begin
      if (rst)        gp_q[g] <= '0;
      else if (gp_we) gp_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/board_cfg_portsel.sv
module board_cfg_portsel
  import board_cfg_pkg::*;
(
  input  logic [BYTE_W-1:0] opt_q,
  output logic              serial_en,
  output logic              com_sel,
  output logic              lpt_en,
  output logic [1:0]        lpt_base_sel
);
  assign serial_en    = opt_q[OPT_SER_EN_BIT];
  assign com_sel      = com_first(opt_q);
  assign lpt_en       = lpt_enabled(opt_q);
  assign lpt_base_sel = lpt_en ? lpt_field(opt_q) : 2'b00;
endmodule

// File: rtl/board_cfg_regs.sv
module board_cfg_regs
  import board_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BOARD_ID = 16'hFBFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        stat_set,
  output logic [7:0]        rd_data,
  output logic              serial_en,
  output logic              com_sel,
  output logic              lpt_en,
  output logic [1:0]        lpt_base_sel
);
  reg_sel_e                      sel;
  logic [BYTE_W-1:0]             stat_q, setup_q, opt_q;
  logic [NUM_GP-1:0][BYTE_W-1:0] gp_q;
  logic                          opt_wr_ok, stat_clr;
  logic [BYTE_W-1:0]             rd_mux;

  board_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  board_cfg_store u_store (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .stat_set  (stat_set),
    .stat_q    (stat_q),
    .setup_q   (setup_q),
    .opt_q     (opt_q),
    .gp_q      (gp_q),
    .opt_wr_ok (opt_wr_ok),
    .stat_clr  (stat_clr)
  );

  board_cfg_portsel u_psel (
    .opt_q        (opt_q),
    .serial_en    (serial_en),
    .com_sel      (com_sel),
    .lpt_en       (lpt_en),
    .lpt_base_sel (lpt_base_sel)
  );

  always_comb begin
    case (sel)
      SEL_STAT:  rd_mux = stat_q;
      SEL_SETUP: rd_mux = setup_q;
      SEL_ID_LO: rd_mux = BOARD_ID[7:0];
      SEL_ID_HI: rd_mux = BOARD_ID[15:8];
      SEL_OPT:   rd_mux = opt_readback(opt_q);
      SEL_GP0:   rd_mux = gp_q[0];
      SEL_GP1:   rd_mux = gp_q[1];
      SEL_GP2:   rd_mux = gp_q[2];
      SEL_GP3:   rd_mux = gp_q[3];
      default:   rd_mux = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= rd_mux;
  end
endmodule

// File: rtl/board_cfg_checker.sv
module board_cfg_checker #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BOARD_ID = 16'hFBFF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [7:0]        stat_set,
  input logic [7:0]        rd_data,
  input logic              serial_en,
  input logic              com_sel,
  input logic              lpt_en,
  input logic [1:0]        lpt_base_sel,
  input logic [7:0]        setup_q,
  input logic [7:0]        opt_q,
  input logic [7:0]        stat_q,
  input logic              stat_clr
);
  logic [15:0] a16;
  logic        known;
  assign a16   = 16'(addr);
  assign known = (a16 == 16'h0091) || (a16 == 16'h0094) || (a16 == 16'h0190) ||
                 (a16 >= 16'h0100 && a16 <= 16'h0105);

  assert_id_lo_R11: assert property (@(posedge clk) disable iff (rst)
    rd_stb && a16 == 16'h0100 |=> rd_data == BOARD_ID[7:0]);

  assert_id_hi_R11: assert property (@(posedge clk) disable iff (rst)
    rd_stb && a16 == 16'h0101 |=> rd_data == BOARD_ID[15:8]);

  assert_open_bus_R12: assert property (@(posedge clk) disable iff (rst)
    rd_stb && !known |=> rd_data == 8'hFF);

  assert_opt_locked_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb && a16 == 16'h0102 && setup_q[7] |=> $stable(opt_q));

  assert_opt_bit3_R7: assert property (@(posedge clk) disable iff (rst)
    rd_stb && a16 == 16'h0102 |=> rd_data[3]);

  assert_lpt_off_R9: assert property (@(posedge clk) disable iff (rst)
    opt_q[6:5] == 2'b11 |-> !lpt_en && lpt_base_sel == 2'b00);

  assert_com_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !serial_en |-> !com_sel);

  assert_stat_clear_R3: assert property (@(posedge clk) disable iff (rst)
    stat_clr && stat_set == 8'h00 |=> stat_q == 8'h00);

  assert_stat_set_R4: assert property (@(posedge clk) disable iff (rst)
    stat_set != 8'h00 |=> (stat_q & $past(stat_set)) == $past(stat_set));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
endmodule

bind board_cfg_regs board_cfg_checker #(.ADDR_W(ADDR_W), .BOARD_ID(BOARD_ID)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .addr         (addr),
  .rd_stb       (rd_stb),
  .wr_stb       (wr_stb),
  .stat_set     (stat_set),
  .rd_data      (rd_data),
  .serial_en    (serial_en),
  .com_sel      (com_sel),
  .lpt_en       (lpt_en),
  .lpt_base_sel (lpt_base_sel),
  .setup_q      (setup_q),
  .opt_q        (opt_q),
  .stat_q       (stat_q),
  .stat_clr     (stat_clr)
);

// File: tb/board_cfg_regs_tb.sv
`timescale 1ns/1ps
module board_cfg_regs_tb_top;
  localparam logic [15:0] ID = 16'hE3FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0]  wr_data = '0, stat_set = '0;
  logic [7:0]  rd_data;
  logic        serial_en, com_sel, lpt_en;
  logic [1:0]  lpt_base_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  bit rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  board_cfg_regs #(.ADDR_W(16), .BOARD_ID(ID)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .stat_set(stat_set), .rd_data(rd_data),
    .serial_en(serial_en), .com_sel(com_sel), .lpt_en(lpt_en),
    .lpt_base_sel(lpt_base_sel)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // monitor: compares each registered read against the scoreboard
  always @(posedge clk) rd_seen <= rd_stb;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual 0x%02h expected nothing (unexpected read)", rd_data);
      end else begin
        chk8(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag,
                    input logic [7:0] setv = 8'h00);
    @(negedge clk); addr = a; rd_stb = 1'b1; stat_set = setv;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_stb = 1'b0; stat_set = 8'h00;
  endtask

  task automatic rd_held(input logic [15:0] a, input logic [7:0] first, input int n,
                         input string tag);
    @(negedge clk); addr = a; rd_stb = 1'b1;
    exp_q.push_back(first); tag_q.push_back(tag);
    for (int i = 1; i < n; i++) begin
      exp_q.push_back(8'h00); tag_q.push_back(tag);
    end
    repeat (n) @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_set(input logic [7:0] v);
    @(negedge clk); stat_set = v;
    @(negedge clk); stat_set = 8'h00;
  endtask

  // expected steering outputs restated from the option field rules
  task automatic chk_out(input string req, input logic [7:0] opt);
    logic       e_ser, e_com, e_lpt;
    logic [1:0] e_sel;
    e_ser = opt[2];
    e_com = opt[2] ? opt[3] : 1'b0;
    e_lpt = (opt[4] == 1'b1) && (opt[6:5] != 2'd3);
    e_sel = e_lpt ? opt[6:5] : 2'd0;
    chk8(req, {3'b0, serial_en, com_sel, lpt_en, lpt_base_sel},
              {3'b0, e_ser, e_com, e_lpt, e_sel});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_out("R1 outputs after reset", 8'h10);
    rd(16'h0102, 8'h18, "R1 option reset readback");
    rd(16'h0091, 8'h00, "R1 status reset");
    rd(16'h0094, 8'h00, "R1 setup reset");
    rd(16'h0190, 8'h00, "R1 gp 0x190 reset");
    rd(16'h0105, 8'h00, "R1 gp 0x105 reset");

    // R11 identifier, R2 hold without strobe
    rd(16'h0100, 8'hFF, "R11 id low");
    rd(16'h0101, 8'hE3, "R11 id high");
    @(negedge clk); addr = 16'h0094;
    @(negedge clk); chk8("R2 rd_data holds without strobe", rd_data, 8'hE3);

    // R5 setup, R10 plain registers
    wr(16'h0094, 8'h5A);
    rd(16'h0094, 8'h5A, "R5 setup readback");
    wr(16'h0103, 8'h11); wr(16'h0104, 8'h22); wr(16'h0105, 8'h33); wr(16'h0190, 8'h44);
    rd(16'h0103, 8'h11, "R10 gp 0x103");
    rd(16'h0104, 8'h22, "R10 gp 0x104");
    rd(16'h0105, 8'h33, "R10 gp 0x105");
    rd(16'h0190, 8'h44, "R10 gp 0x190");

    // R8/R9/R7 option decode patterns
    wr(16'h0102, 8'h2C); chk_out("R8 serial first, lpt off", 8'h2C);
    rd(16'h0102, 8'h2C, "R7 readback bit3 already set");
    wr(16'h0102, 8'h54); chk_out("R9 lpt2 with serial second", 8'h54);
    rd(16'h0102, 8'h5C, "R7 readback forces bit3");
    wr(16'h0102, 8'h70); chk_out("R9 field 3 disables lpt", 8'h70);
    wr(16'h0102, 8'h08); chk_out("R8 com_sel low while serial off", 8'h08);
    wr(16'h0102, 8'h30); chk_out("R9 lpt1", 8'h30);

    // R6 lock gating
    wr(16'h0094, 8'h80);
    wr(16'h0102, 8'h04); chk_out("R6 locked write ignored", 8'h30);
    rd(16'h0102, 8'h38, "R6 locked option unchanged");
    wr(16'h0094, 8'h00);
    wr(16'h0102, 8'h04); chk_out("R6 unlocked write accepted", 8'h04);
    rd(16'h0102, 8'h0C, "R6 unlocked option readback");

    // R3 clear on read, held strobe clears once
    pulse_set(8'h81);
    rd(16'h0091, 8'h81, "R3 status read");
    rd(16'h0091, 8'h00, "R3 status cleared");
    pulse_set(8'h24);
    rd_held(16'h0091, 8'h24, 3, "R3 held strobe");
    // held strobe: a set arriving mid-strobe survives the later cycles
    pulse_set(8'h01);
    @(negedge clk); addr = 16'h0091; rd_stb = 1'b1;
    exp_q.push_back(8'h01); tag_q.push_back("R3 held first cycle");
    @(negedge clk); stat_set = 8'h10;
    exp_q.push_back(8'h00); tag_q.push_back("R3 held second cycle");
    @(negedge clk); stat_set = 8'h00;
    exp_q.push_back(8'h10); tag_q.push_back("R3 no second clear");
    @(negedge clk); rd_stb = 1'b0;
    rd(16'h0091, 8'h10, "R3 set during held strobe kept");

    // R4 set in same cycle as clearing read
    pulse_set(8'h05);
    rd(16'h0091, 8'h05, "R4 read returns pre-clear value", 8'h40);
    rd(16'h0091, 8'h40, "R4 same-cycle set survives clear");
    rd(16'h0091, 8'h00, "R4 cleared afterwards");

    // R12 open bus and ignored writes
    rd(16'h0092, 8'hFF, "R12 undecoded 0x0092");
    rd(16'h0106, 8'hFF, "R12 undecoded 0x0106");
    rd(16'h1091, 8'hFF, "R12 undecoded 0x1091");
    wr(16'h0100, 8'h12);
    rd(16'h0100, 8'hFF, "R12 id write ignored");
    wr(16'h0091, 8'h33);
    rd(16'h0091, 8'h00, "R12 status write ignored");
    wr(16'h0107, 8'h99);
    rd(16'h0103, 8'h11, "R12 undecoded write leaves gp");
    chk_out("R12 undecoded write leaves option", 8'h04);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule